// File: doc/BRIEF.md
# Transaction Conflict Arbiter

This block settles memory-access conflicts for a single core that runs hardware transactions under eager conflict detection. When the core's conflict tracker finds that a forwarded request from another core collides with the running transaction, the arbiter decides the reply. In the default mode it refuses the request with a negative acknowledgement (nack). In the alternative mode the requester wins: the local transaction aborts and yields.

When the core's own request is refused, the arbiter does not abort. It stalls the core and asks for the access to be reissued at a fixed, programmable interval until a normal response comes back. Each transaction carries an age stamp taken when it first begins. A transaction that refuses an older requester marks itself as a possible member of a dependency cycle. If it is later refused by an older transaction while that mark is set, it aborts, so only the younger side of a cycle gives way. The stamp survives an abort, so a restarted transaction keeps its age and in time becomes the oldest. The stamp is released on commit.

Top module: `txn_conflict_arbiter`

## Requirements
- R1: After reset, `reply_nack`, `local_abort`, `retry_req`, `stalled`, `txn_active`, `ts_held` and `cycle_flag` are all 0.
- R2: `txn_begin` while no transaction is active makes `txn_active` 1 after the next edge. If no stamp is held, it also loads `now_time` into `local_ts` and sets `ts_held`.
- R3: In nack mode (`reqwins_mode`=0), `conf_valid` during an active transaction gives a one-cycle `reply_nack` on the cycle after it, and no abort.
- R4: A nack sent to a requester older than the local stamp sets `cycle_flag` on the same edge. A nack to a younger or equal-aged requester leaves it unchanged.
- R5: `nack_valid` during an active transaction that does not lead to an abort raises `stalled` after the next edge. `retry_req` then pulses for one cycle every `retry_gap` cycles (a value of 0 acts as 1), the first pulse `retry_gap` cycles after `stalled` rose.
- R6: `resp_ok` ends the stall after the next edge, and no further `retry_req` follows.
- R7: `nack_valid` from a transaction older than the local stamp while `cycle_flag` is 1 gives a one-cycle `local_abort`. After it, `txn_active`, `cycle_flag` and `stalled` are 0.
- R8: `nack_valid` from a younger transaction while `cycle_flag` is 1 only stalls, as in R5.
- R9: In requester-wins mode (`reqwins_mode`=1), `conf_valid` during an active transaction gives `local_abort` on the next cycle and never `reply_nack`.
- R10: An abort keeps `ts_held` at 1 and `local_ts` unchanged. The next `txn_begin` reuses that stamp and ignores `now_time`.
- R11: `txn_commit` clears `txn_active`, `ts_held` and `cycle_flag`. The next `txn_begin` loads a fresh stamp.
- R12: `conf_valid` and `nack_valid` are ignored while no transaction is active: no nack, no abort, no stall.
- R13: Stamp `a` is older than stamp `b` when `a - b`, taken modulo 2^TS_W, has its top bit set. With 8-bit stamps, 250 is therefore older than 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_time | input | TS_W | Global time, sampled as the stamp at first begin |
| txn_begin | input | 1 | Transaction starts or restarts |
| txn_commit | input | 1 | Transaction committed |
| reqwins_mode | input | 1 | 1 selects requester-wins, 0 selects nack |
| retry_gap | input | GAP_W | Cycles between reissues while stalled |
| conf_valid | input | 1 | Tracker found a conflict with a forwarded request |
| conf_ts | input | TS_W | Stamp of that requester |
| nack_valid | input | 1 | The core's own request was refused |
| nack_ts | input | TS_W | Stamp of the refusing transaction |
| resp_ok | input | 1 | A normal response arrived for the core's request |
| reply_nack | output | 1 | Refuse the forwarded request |
| local_abort | output | 1 | Abort the local transaction |
| retry_req | output | 1 | Reissue the stalled request |
| stalled | output | 1 | Core is waiting on a refused request |
| txn_active | output | 1 | A transaction is running |
| ts_held | output | 1 | A stamp is held |
| cycle_flag | output | 1 | Possible dependency cycle seen |
| local_ts | output | TS_W | Held stamp |

## Verification
The bench builds the block with 8-bit stamps and a 4-bit retry interval. The narrow stamp lets the wrap-around age order be tested with plain values such as 5 against 250. Equal stamps are also checked. A retry interval of 3 keeps several periodic reissues inside a short window, so the exact pulse cycles and the silence after a normal response can be compared cycle by cycle.

// File: rtl/tca_pkg.sv
// Shared types for the transaction conflict arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package tca_pkg;

    // Per-cycle decision of the arbiter.
    typedef struct packed {
        logic nack;         // refuse the forwarded request
        logic abort;        // abort the local transaction
        logic flag_set;     // mark possible dependency cycle
        logic stall_start;  // begin or restart a stall
    } tca_verdict_t;

    // Retry timer state.
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_WAIT = 1'b1
    } tca_tmr_state_t;

endpackage

// File: rtl/tca_decider.sv
// Combinational conflict decision for one cycle.
// Assumes: the stamp and flag inputs are the registered state of the running
// transaction. Age order is modular: a is older than b when (a-b) is negative.
module tca_decider
    import tca_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic            in_txn,
    input  logic            reqwins_mode,
    input  logic [TS_W-1:0] my_ts,
    input  logic            my_flag,
    input  logic            conf_valid,
    input  logic [TS_W-1:0] conf_ts,
    input  logic            nack_valid,
    input  logic [TS_W-1:0] nack_ts,
    output tca_verdict_t    verdict
);

    localparam int MSB = TS_W - 1;

    logic [TS_W-1:0] conf_diff;
    logic [TS_W-1:0] nack_diff;
    logic            conf_older;
    logic            nack_older;
    logic            conf_live;
    logic            nack_live;
    logic            nack_abort;
    logic            conf_abort;

    // Modular age differences of the other transactions against ours.
    always_comb begin
        conf_diff  = conf_ts - my_ts;
        nack_diff  = nack_ts - my_ts;
        conf_older = conf_diff[MSB];
        nack_older = nack_diff[MSB];
    end

    // Build the verdict from live events, mode and cycle flag.
    always_comb begin
        conf_live  = conf_valid && in_txn;
        nack_live  = nack_valid && in_txn;
        conf_abort = conf_live && reqwins_mode;
        nack_abort = nack_live && my_flag && nack_older;
        verdict.abort       = conf_abort || nack_abort;
        verdict.nack        = conf_live && !reqwins_mode;
        verdict.flag_set    = conf_live && !reqwins_mode && conf_older && !nack_abort;
        verdict.stall_start = nack_live && !verdict.abort;
    end

endmodule

// File: rtl/tca_age_keeper.sv
// Holds the transaction state: active bit, age stamp, stamp-held bit and
// possible-cycle flag.
// Assumes: abort has priority over commit, commit over begin. A begin while
// active is ignored. The stamp survives aborts and is released on commit.
module tca_age_keeper #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] now_time,
    input  logic            begin_req,
    input  logic            commit_req,
    input  logic            abort_req,
    input  logic            flag_set,
    output logic            in_txn,
    output logic [TS_W-1:0] stamp,
    output logic            held,
    output logic            flag
);

    // Update active bit, stamp and flag by priority abort > commit > begin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_txn <= 1'b0;
            stamp  <= '0;
            held   <= 1'b0;
            flag   <= 1'b0;
        end else if (abort_req) begin
            in_txn <= 1'b0;
            flag   <= 1'b0;
        end else if (commit_req) begin
            in_txn <= 1'b0;
            held   <= 1'b0;
            flag   <= 1'b0;
        end else begin
            if (begin_req && !in_txn) begin
                in_txn <= 1'b1;
                held   <= 1'b1;
                if (!held) begin
                    stamp <= now_time;
                end
            end
            if (flag_set) begin
                flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tca_retry_timer.sv
// Stall tracker with a periodic reissue pulse.
// Assumes: a gap of 0 acts as 1. Halt (abort/commit) beats start, start beats
// the normal-response release.
module tca_retry_timer
    import tca_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             halt,
    input  logic             release_ok,
    input  logic [GAP_W-1:0] gap,
    output logic             stalled,
    output logic             fire
);

    tca_tmr_state_t   state;
    logic [GAP_W-1:0] count;
    logic [GAP_W-1:0] reload;

    // Clamp the programmed gap to at least one cycle.
    always_comb begin
        reload = (gap == '0) ? GAP_W'(1) : gap;
    end

    // Count down while stalled and pulse fire at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TMR_IDLE;
            count <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (halt) begin
                state <= TMR_IDLE;
            end else if (start) begin
                state <= TMR_WAIT;
                count <= reload;
            end else if (release_ok) begin
                state <= TMR_IDLE;
            end else if (state == TMR_WAIT) begin
                if (count <= GAP_W'(1)) begin
                    fire  <= 1'b1;
                    count <= reload;
                end else begin
                    count <= count - GAP_W'(1);
                end
            end
        end
    end

    // Expose the stall state.
    always_comb begin
        stalled = (state == TMR_WAIT);
    end

endmodule

// File: rtl/txn_conflict_arbiter.sv
// Conflict arbiter for one core running eager-detection transactions.
// Decides nack or local abort on detected conflicts, stalls and reissues on
// received nacks, and uses begin stamps plus a cycle flag to abort only the
// younger side of a possible deadlock.
// Assumes: one conflict and one nack event at most per cycle; the tracker
// and messaging sit outside. Responses are registered, one cycle after input.
module txn_conflict_arbiter
    import tca_pkg::*;
#(
    parameter int TS_W  = 16,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  now_time,
    input  logic             txn_begin,
    input  logic             txn_commit,
    input  logic             reqwins_mode,
    input  logic [GAP_W-1:0] retry_gap,
    input  logic             conf_valid,
    input  logic [TS_W-1:0]  conf_ts,
    input  logic             nack_valid,
    input  logic [TS_W-1:0]  nack_ts,
    input  logic             resp_ok,
    output logic             reply_nack,
    output logic             local_abort,
    output logic             retry_req,
    output logic             stalled,
    output logic             txn_active,
    output logic             ts_held,
    output logic             cycle_flag,
    output logic [TS_W-1:0]  local_ts
);

    tca_verdict_t verdict;
    logic         stop_stall;

    tca_decider #(.TS_W(TS_W)) u_decide (
        .in_txn       (txn_active),
        .reqwins_mode (reqwins_mode),
        .my_ts        (local_ts),
        .my_flag      (cycle_flag),
        .conf_valid   (conf_valid),
        .conf_ts      (conf_ts),
        .nack_valid   (nack_valid),
        .nack_ts      (nack_ts),
        .verdict      (verdict)
    );

    tca_age_keeper #(.TS_W(TS_W)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .now_time   (now_time),
        .begin_req  (txn_begin),
        .commit_req (txn_commit),
        .abort_req  (verdict.abort),
        .flag_set   (verdict.flag_set),
        .in_txn     (txn_active),
        .stamp      (local_ts),
        .held       (ts_held),
        .flag       (cycle_flag)
    );

    // Abort or commit ends any stall outright.
    always_comb begin
        stop_stall = verdict.abort || txn_commit;
    end

    tca_retry_timer #(.GAP_W(GAP_W)) u_retry (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (verdict.stall_start),
        .halt       (stop_stall),
        .release_ok (resp_ok),
        .gap        (retry_gap),
        .stalled    (stalled),
        .fire       (retry_req)
    );

    // Register the reply and abort decisions as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reply_nack  <= 1'b0;
            local_abort <= 1'b0;
        end else begin
            reply_nack  <= verdict.nack;
            local_abort <= verdict.abort;
        end
    end

endmodule

// File: rtl/tca_checker.sv
// Port-level properties of the conflict arbiter, bound to the top module.
module tca_checker #(
    parameter int TS_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            txn_commit,
    input logic            reqwins_mode,
    input logic            conf_valid,
    input logic            reply_nack,
    input logic            local_abort,
    input logic            retry_req,
    input logic            stalled,
    input logic            txn_active,
    input logic            ts_held,
    input logic            cycle_flag,
    input logic [TS_W-1:0] local_ts
);

    assert_nack_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conf_valid && txn_active && !reqwins_mode |=> reply_nack && !local_abort);

    assert_reqwins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conf_valid && txn_active && reqwins_mode |=> local_abort && !reply_nack);

    assert_retry_only_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> $past(stalled));

    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        local_abort |-> !txn_active && !cycle_flag && !stalled);

    assert_abort_keeps_stamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        local_abort |-> ts_held && local_ts == $past(local_ts));

    assert_commit_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(txn_commit) && !local_abort |-> !ts_held && !cycle_flag);

    assert_idle_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
        conf_valid && !txn_active |=> !reply_nack && !local_abort);

endmodule

bind txn_conflict_arbiter tca_checker #(.TS_W(TS_W)) u_tca_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .txn_commit   (txn_commit),
    .reqwins_mode (reqwins_mode),
    .conf_valid   (conf_valid),
    .reply_nack   (reply_nack),
    .local_abort  (local_abort),
    .retry_req    (retry_req),
    .stalled      (stalled),
    .txn_active   (txn_active),
    .ts_held      (ts_held),
    .cycle_flag   (cycle_flag),
    .local_ts     (local_ts)
);

// File: tb/txn_conflict_arbiter_test.sv
module txn_conflict_arbiter_test;

    localparam int TS_W  = 8;
    localparam int GAP_W = 4;
    localparam int NVEC  = 7;

    // {mode, local stamp, requester stamp, exp nack, exp abort, exp flag}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 8'd100, 8'd50,  3'b101},
        {1'b0, 8'd50,  8'd100, 3'b100},
        {1'b1, 8'd100, 8'd50,  3'b010},
        {1'b1, 8'd50,  8'd100, 3'b010},
        {1'b0, 8'd5,   8'd250, 3'b101},
        {1'b0, 8'd250, 8'd5,   3'b100},
        {1'b0, 8'd10,  8'd10,  3'b100}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TS_W-1:0]  now_time = '0;
    logic             txn_begin = 1'b0;
    logic             txn_commit = 1'b0;
    logic             reqwins_mode = 1'b0;
    logic [GAP_W-1:0] retry_gap = 4'd3;
    logic             conf_valid = 1'b0;
    logic [TS_W-1:0]  conf_ts = '0;
    logic             nack_valid = 1'b0;
    logic [TS_W-1:0]  nack_ts = '0;
    logic             resp_ok = 1'b0;
    logic             reply_nack, local_abort, retry_req, stalled;
    logic             txn_active, ts_held, cycle_flag;
    logic [TS_W-1:0]  local_ts;

    int compared = 0;
    int mismatched = 0;
    bit seen_retry;

    always #4 clk = ~clk;

    txn_conflict_arbiter #(.TS_W(TS_W), .GAP_W(GAP_W)) uut (
        .clk(clk), .rst_n(rst_n), .now_time(now_time), .txn_begin(txn_begin),
        .txn_commit(txn_commit), .reqwins_mode(reqwins_mode), .retry_gap(retry_gap),
        .conf_valid(conf_valid), .conf_ts(conf_ts), .nack_valid(nack_valid),
        .nack_ts(nack_ts), .resp_ok(resp_ok), .reply_nack(reply_nack),
        .local_abort(local_abort), .retry_req(retry_req), .stalled(stalled),
        .txn_active(txn_active), .ts_held(ts_held), .cycle_flag(cycle_flag),
        .local_ts(local_ts)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic start_txn(input logic [TS_W-1:0] t);
        now_time = t;
        txn_begin = 1'b1;
        step();
        txn_begin = 1'b0;
    endtask

    task automatic hit_conflict(input logic [TS_W-1:0] t);
        conf_ts = t;
        conf_valid = 1'b1;
        step();
        conf_valid = 1'b0;
    endtask

    task automatic hit_nack(input logic [TS_W-1:0] t);
        nack_ts = t;
        nack_valid = 1'b1;
        step();
        nack_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 reply_nack", reply_nack, 0);
        check("R1 local_abort", local_abort, 0);
        check("R1 retry_req", retry_req, 0);
        check("R1 stalled", stalled, 0);
        check("R1 txn_active", txn_active, 0);
        check("R1 ts_held", ts_held, 0);
        check("R1 cycle_flag", cycle_flag, 0);

        // R3 R4 R9 R13: conflict verdict table
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            reqwins_mode = VEC[i][19];
            start_txn(VEC[i][18:11]);
            hit_conflict(VEC[i][10:3]);
            check("R3/R9 reply_nack", reply_nack, VEC[i][2]);
            check("R9 local_abort", local_abort, VEC[i][1]);
            check("R4/R13 cycle_flag", cycle_flag, VEC[i][0]);
        end
        reqwins_mode = 1'b0;

        // R2 begin loads the stamp
        do_reset();
        start_txn(8'd100);
        check("R2 txn_active", txn_active, 1);
        check("R2 local_ts", local_ts, 100);
        check("R2 ts_held", ts_held, 1);

        // R5 stall and periodic retry, gap 3
        hit_nack(8'd200);
        check("R5 stalled", stalled, 1);
        check("R5 no abort", local_abort, 0);
        check("R5 retry early", retry_req, 0);
        step();
        check("R5 retry k+1", retry_req, 0);
        step();
        check("R5 retry k+2", retry_req, 0);
        step();
        check("R5 retry k+3", retry_req, 1);
        step();
        check("R5 retry k+4", retry_req, 0);
        step();
        step();
        check("R5 retry k+6", retry_req, 1);

        // R6 normal response ends stall
        resp_ok = 1'b1;
        step();
        resp_ok = 1'b0;
        check("R6 stalled", stalled, 0);
        seen_retry = 1'b0;
        for (int j = 0; j < 8; j++) begin
            step();
            if (retry_req) seen_retry = 1'b1;
        end
        check("R6 no retry", seen_retry, 0);

        // R8 flag set, nacked by younger: stall only
        hit_conflict(8'd50);
        check("R8 flag set", cycle_flag, 1);
        hit_nack(8'd200);
        check("R8 no abort", local_abort, 0);
        check("R8 stalled", stalled, 1);
        resp_ok = 1'b1;
        step();
        resp_ok = 1'b0;

        // R7 flag set, nacked by older: abort
        hit_nack(8'd50);
        check("R7 local_abort", local_abort, 1);
        check("R7 txn_active", txn_active, 0);
        check("R7 cycle_flag", cycle_flag, 0);
        check("R7 stalled", stalled, 0);
        step();
        check("R7 pulse", local_abort, 0);

        // R10 stamp kept across abort
        check("R10 ts_held", ts_held, 1);
        start_txn(8'd77);
        check("R10 local_ts", local_ts, 100);

        // R11 commit releases stamp
        txn_commit = 1'b1;
        step();
        txn_commit = 1'b0;
        check("R11 ts_held", ts_held, 0);
        check("R11 txn_active", txn_active, 0);
        start_txn(8'd77);
        check("R11 fresh stamp", local_ts, 77);
        txn_commit = 1'b1;
        step();
        txn_commit = 1'b0;

        // R12 events ignored while idle
        hit_conflict(8'd1);
        check("R12 reply_nack", reply_nack, 0);
        check("R12 cycle_flag", cycle_flag, 0);
        hit_nack(8'd1);
        check("R12 stalled", stalled, 0);
        check("R12 local_abort", local_abort, 0);

        // R5 gap 0 acts as 1
        retry_gap = 4'd0;
        start_txn(8'd30);
        hit_nack(8'd90);
        step();
        check("R5 gap0 retry", retry_req, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule